// File: doc/BRIEF.md
# Register Redirection Lookup Table

This block translates the 5-bit register numbers carried by instructions into 6-bit indices of a 64-entry register file. It is a small content-addressed table: each slot holds an enable flag, a 5-bit key (the operand number it captures), a 6-bit target index, a flag saying whether the redirected register acts as a vector or stays scalar, and a 2-bit element-width override code. A lookup compares the operand against the key of every slot at once. The first enabled slot that matches supplies the target and its attributes. When no enabled slot matches, the operand passes through unchanged as a scalar at the default width.

A write port loads one slot per cycle, and a write can also turn a slot off. The lookup port takes a request strobe and an operand, and returns one registered result on the next cycle. The result carries a hit flag, the index, the vector flag, the raw width code and the width decoded to a bit count. The decode uses a parameterised default element width: code 00 gives the default, 01 gives half of it, 10 gives twice it and 11 gives a fixed 8 bits.

Top module: `reg_redirect_table`

## Requirements
- R1: After reset every slot is disabled, so every operand looks up as a miss, and res_valid is low while reset is held.
- R2: A lookup whose operand equals the key of an enabled slot returns res_hit=1 and that slot's 6-bit target on res_idx, its vector flag on res_vec and its width code on res_ew.
- R3: A lookup that matches no enabled slot returns res_hit=0, res_idx equal to the operand zero-extended to 6 bits (bit 5 = 0), res_vec=0 and res_ew=00.
- R4: A disabled slot whose key equals the operand has no effect on the result.
- R5: When several enabled slots hold the same key, the slot with the lowest number supplies the result.
- R6: A write takes effect on lookups requested from the next cycle onward. A lookup requested in the same cycle as a write sees the table as it was before that write.
- R7: res_valid is high in exactly the cycle after a cycle with lk_valid high, and each request yields exactly one result.
- R8: res_bits decodes res_ew as follows: 00 gives DEF_W, 01 gives DEF_W/2, 10 gives DEF_W*2 and 11 gives 8. A miss reports DEF_W.
- R9: Writing a slot replaces all of its previous contents. Writing it with wr_active=0 removes its mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Load the slot addressed by wr_slot |
| wr_slot | input | SLOT_W | Slot number to load |
| wr_active | input | 1 | Enable flag for the loaded slot |
| wr_key | input | 5 | Operand number the slot captures |
| wr_target | input | 6 | Redirected register index |
| wr_vec | input | 1 | 1 = vector, 0 = scalar |
| wr_ew | input | 2 | Element-width override code |
| lk_valid | input | 1 | Lookup request strobe |
| lk_reg | input | 5 | Operand register number to translate |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_hit | output | 1 | An enabled slot matched |
| res_idx | output | 6 | Translated register index |
| res_vec | output | 1 | Vector flag of the result |
| res_ew | output | 2 | Width code of the result |
| res_bits | output | BITS_W | Decoded element width in bits |

## Verification
A corrupted slot, or a wrong choice among matching slots, shows up on res_idx, res_vec or res_ew in the result cycle of the first lookup of the affected key. No such lookup comes later than two cycles after the bad write. A slot whose enable flag is stuck looks like a spurious hit or a spurious pass-through on that same lookup. The bench therefore follows every table change with lookups of the affected keys, including a lookup issued in the same cycle as a write. It also sweeps all 32 operands so that a stray match on any other key is caught.

// File: rtl/rrt_pkg.sv
// Package rrt_pkg
// Shared widths, the element-width code and the slot record used by
// the register redirection table. No assumptions beyond the fixed
// 5-bit operand and 6-bit target sizes.
package rrt_pkg;
    localparam int KEY_W = 5;
    localparam int IDX_W = 6;

    typedef enum logic [1:0] {
        EW_DEFAULT = 2'b00,
        EW_HALF    = 2'b01,
        EW_DOUBLE  = 2'b10,
        EW_BYTE    = 2'b11
    } ew_code_t;

    typedef struct packed {
        logic              active;
        logic [KEY_W-1:0]  key;
        logic [IDX_W-1:0]  target;
        logic              is_vec;
        ew_code_t          ew;
    } map_entry_t;
endpackage

// File: rtl/rrt_store.sv
// Module rrt_store
// Holds the slot records and loads one slot per cycle from the write
// port. All slots are disabled by a synchronous active-low reset.
// Assumes wr_slot values at or above NSLOT are simply not loaded.
module rrt_store
    import rrt_pkg::*;
#(
    parameter int NSLOT  = 16,
    parameter int SLOT_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [SLOT_W-1:0]      wr_slot,
    input  map_entry_t             wr_data,
    output map_entry_t [NSLOT-1:0] slots_o
);
    map_entry_t [NSLOT-1:0] slots_q;

    // Purpose: clear every slot on reset, otherwise load the addressed slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NSLOT; i++) begin
                if (wr_slot == SLOT_W'(i)) slots_q[i] <= wr_data;
            end
        end
    end

    assign slots_o = slots_q;

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (slots_q[0].active == 1'b0 && slots_q[NSLOT-1].active == 1'b0)); // R1

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (32'(wr_slot) < NSLOT)) |=> (slots_q[$past(wr_slot)] == $past(wr_data))); // R9
endmodule

// File: rtl/rrt_match.sv
// Module rrt_match
// Compares the operand against every slot key in parallel, keeps the
// enabled matches and picks the lowest-numbered one. Purely
// combinational; clk and rst_n serve the local assertions only.
module rrt_match
    import rrt_pkg::*;
#(
    parameter int NSLOT  = 16,
    parameter int SLOT_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  map_entry_t [NSLOT-1:0] slots_i,
    input  logic [KEY_W-1:0]       key_i,
    output logic                   hit_o,
    output logic [SLOT_W-1:0]      slot_o,
    output map_entry_t             entry_o
);
    logic [NSLOT-1:0] match_vec;
    logic [NSLOT-1:0] win_vec;

    // One comparator per slot.
    for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
        assign match_vec[g] = slots_i[g].active && (slots_i[g].key == key_i);
    end

    // Purpose: isolate the lowest set bit so the smallest slot number wins.
    always_comb win_vec = match_vec & (~match_vec + NSLOT'(1));

    assign hit_o = |match_vec;

    // Purpose: one-hot select of the winning slot and its number.
    always_comb begin
        entry_o = '0;
        slot_o  = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (win_vec[i]) begin
                entry_o = entry_o | slots_i[i];
                slot_o  = slot_o | SLOT_W'(i);
            end
        end
    end

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_vec) && (hit_o == (win_vec != '0))); // R5

    AST_WINNER_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (slots_i[slot_o].active && slots_i[slot_o].key == key_i)); // R2
endmodule

// File: rtl/rrt_width_dec.sv
// Module rrt_width_dec
// Turns a 2-bit element-width code into a bit count, relative to the
// default width DEF_W. Assumes BITS_W can hold 2*DEF_W.
module rrt_width_dec
    import rrt_pkg::*;
#(
    parameter int DEF_W  = 32,
    parameter int BITS_W = 7
) (
    input  ew_code_t          code_i,
    output logic [BITS_W-1:0] bits_o
);
    localparam logic [BITS_W-1:0] W_DEF  = BITS_W'(DEF_W);
    localparam logic [BITS_W-1:0] W_HALF = BITS_W'(DEF_W / 2);
    localparam logic [BITS_W-1:0] W_DBL  = BITS_W'(DEF_W * 2);
    localparam logic [BITS_W-1:0] W_BYTE = BITS_W'(8);

    // Purpose: map the code to its width.
    always_comb begin
        unique case (code_i)
            EW_HALF:   bits_o = W_HALF;
            EW_DOUBLE: bits_o = W_DBL;
            EW_BYTE:   bits_o = W_BYTE;
            default:   bits_o = W_DEF;
        endcase
    end
endmodule

// File: rtl/reg_redirect_table.sv
// Module reg_redirect_table
// Top of the register redirection table. It stores the slots, searches
// them by key, decodes the width and registers one result per request.
// Assumes one lookup and one write at most per cycle; a lookup in the
// same cycle as a write sees the old table.
module reg_redirect_table
    import rrt_pkg::*;
#(
    parameter int NSLOT  = 16,
    parameter int DEF_W  = 32,
    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int BITS_W = $clog2(2 * DEF_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              wr_active,
    input  logic [4:0]        wr_key,
    input  logic [5:0]        wr_target,
    input  logic              wr_vec,
    input  logic [1:0]        wr_ew,
    input  logic              lk_valid,
    input  logic [4:0]        lk_reg,
    output logic              res_valid,
    output logic              res_hit,
    output logic [5:0]        res_idx,
    output logic              res_vec,
    output logic [1:0]        res_ew,
    output logic [BITS_W-1:0] res_bits
);
    map_entry_t [NSLOT-1:0] slots;
    map_entry_t             wr_data;
    map_entry_t             found;
    logic                   found_hit;
    logic [SLOT_W-1:0]      found_slot;
    ew_code_t               sel_ew;
    logic [IDX_W-1:0]       sel_idx;
    logic                   sel_vec;
    logic [BITS_W-1:0]      sel_bits;

    // Purpose: pack the write-port fields into one slot record.
    always_comb begin
        wr_data.active = wr_active;
        wr_data.key    = wr_key;
        wr_data.target = wr_target;
        wr_data.is_vec = wr_vec;
        wr_data.ew     = ew_code_t'(wr_ew);
    end

    rrt_store #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_slot (wr_slot),
        .wr_data (wr_data),
        .slots_o (slots)
    );

    rrt_match #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) match_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .slots_i (slots),
        .key_i   (lk_reg),
        .hit_o   (found_hit),
        .slot_o  (found_slot),
        .entry_o (found)
    );

    // Purpose: take the hit entry's fields, or pass the operand through.
    always_comb begin
        if (found_hit) begin
            sel_idx = found.target;
            sel_vec = found.is_vec;
            sel_ew  = found.ew;
        end else begin
            sel_idx = {1'b0, lk_reg};
            sel_vec = 1'b0;
            sel_ew  = EW_DEFAULT;
        end
    end

    rrt_width_dec #(.DEF_W(DEF_W), .BITS_W(BITS_W)) dec_i (
        .code_i (sel_ew),
        .bits_o (sel_bits)
    );

    // Purpose: register the result one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_idx   <= '0;
            res_vec   <= 1'b0;
            res_ew    <= 2'b00;
            res_bits  <= '0;
        end else begin
            res_valid <= lk_valid;
            if (lk_valid) begin
                res_hit  <= found_hit;
                res_idx  <= sel_idx;
                res_vec  <= sel_vec;
                res_ew   <= sel_ew;
                res_bits <= sel_bits;
            end
        end
    end

    logic unused_slot;
    assign unused_slot = ^found_slot;

    AST_REQ_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid); // R7

    AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid); // R7

    AST_MISS_PASSES_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (res_hit || (res_idx == {1'b0, $past(lk_reg)} && !res_vec && res_ew == 2'b00))); // R3

    AST_BYTE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_ew == 2'b11) |-> (res_bits == BITS_W'(8))); // R8
endmodule

// File: tb/reg_redirect_table_tb_top.sv
// Scoreboard bench for reg_redirect_table: the driver tasks keep a model
// of the slots, push the expected result of each lookup into a queue,
// and a monitor pops and compares on every res_valid.
module reg_redirect_table_tb_top;
    localparam int NSLOT  = 16;
    localparam int DEF_W  = 32;
    localparam int SLOT_W = 4;
    localparam int BITS_W = 7;

    typedef struct {
        logic       hit;
        logic [5:0] idx;
        logic       vec;
        logic [1:0] ew;
        int         bits;
        string      tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [SLOT_W-1:0] wr_slot = '0;
    logic              wr_active = 1'b0;
    logic [4:0]        wr_key = '0;
    logic [5:0]        wr_target = '0;
    logic              wr_vec = 1'b0;
    logic [1:0]        wr_ew = '0;
    logic              lk_valid = 1'b0;
    logic [4:0]        lk_reg = '0;
    logic              res_valid;
    logic              res_hit;
    logic [5:0]        res_idx;
    logic              res_vec;
    logic [1:0]        res_ew;
    logic [BITS_W-1:0] res_bits;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    logic       m_act [NSLOT];
    logic [4:0] m_key [NSLOT];
    logic [5:0] m_tgt [NSLOT];
    logic       m_vec [NSLOT];
    logic [1:0] m_ew  [NSLOT];

    always #10 clk = ~clk;

    reg_redirect_table #(.NSLOT(NSLOT), .DEF_W(DEF_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_active(wr_active), .wr_key(wr_key),
        .wr_target(wr_target), .wr_vec(wr_vec), .wr_ew(wr_ew),
        .lk_valid(lk_valid), .lk_reg(lk_reg),
        .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx),
        .res_vec(res_vec), .res_ew(res_ew), .res_bits(res_bits)
    );

    function automatic int width_of(logic [1:0] c);
        case (c)
            2'b01:   return DEF_W / 2;
            2'b10:   return DEF_W * 2;
            2'b11:   return 8;
            default: return DEF_W;
        endcase
    endfunction

    function automatic exp_t model(logic [4:0] r, string tag);
        exp_t e;
        e.hit = 1'b0; e.idx = {1'b0, r}; e.vec = 1'b0; e.ew = 2'b00; e.tag = tag;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (m_act[i] && m_key[i] == r) begin
                e.hit = 1'b1; e.idx = m_tgt[i]; e.vec = m_vec[i]; e.ew = m_ew[i];
            end
        end
        e.bits = width_of(e.ew);
        return e;
    endfunction

    // One cycle: an optional write plus an optional lookup; the lookup is
    // modelled against the table before the write (R6).
    task automatic step(bit do_wr, int slot, bit act, logic [4:0] key, logic [5:0] tgt,
                        bit vec, logic [1:0] ew, bit do_lk, logic [4:0] r, string tag);
        @(negedge clk);
        lk_valid = do_lk; lk_reg = r;
        if (do_lk) sb.push_back(model(r, tag));
        wr_en = do_wr; wr_slot = SLOT_W'(slot); wr_active = act; wr_key = key;
        wr_target = tgt; wr_vec = vec; wr_ew = ew;
        if (do_wr) begin
            m_act[slot] = act; m_key[slot] = key; m_tgt[slot] = tgt;
            m_vec[slot] = vec; m_ew[slot] = ew;
        end
    endtask

    task automatic wr(int slot, bit act, logic [4:0] key, logic [5:0] tgt, bit vec, logic [1:0] ew);
        step(1'b1, slot, act, key, tgt, vec, ew, 1'b0, 5'd0, "");
    endtask

    task automatic lk(logic [4:0] r, string tag);
        step(1'b0, 0, 1'b0, 5'd0, 6'd0, 1'b0, 2'b00, 1'b1, r, tag);
    endtask

    task automatic idle();
        step(1'b0, 0, 1'b0, 5'd0, 6'd0, 1'b0, 2'b00, 1'b0, 5'd0, "");
    endtask

    // Monitor: compare each result against the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R7: result without request, got res_valid=1 expected 0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (res_hit !== e.hit || res_idx !== e.idx || res_vec !== e.vec ||
                    res_ew !== e.ew || int'(res_bits) != e.bits) begin
                    errors++;
                    $display("FAIL %s: got hit=%0b idx=%0d vec=%0b ew=%0d bits=%0d expected hit=%0b idx=%0d vec=%0b ew=%0d bits=%0d",
                             e.tag, res_hit, res_idx, res_vec, res_ew, res_bits,
                             e.hit, e.idx, e.vec, e.ew, e.bits);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < NSLOT; i++) begin
            m_act[i] = 1'b0; m_key[i] = '0; m_tgt[i] = '0; m_vec[i] = 1'b0; m_ew[i] = '0;
        end
        lk_valid = 1'b1;
        repeat (3) @(negedge clk);
        checks++;
        if (res_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: res_valid during reset got %0b expected 0", res_valid);
        end
        lk_valid = 1'b0;
        rst_n = 1'b1;

        // R1 R3: empty table, pass-through
        lk(5'd0, "R1");
        lk(5'd7, "R3");
        lk(5'd31, "R3");
        idle();

        // R2 R8: half width, vector
        wr(3, 1'b1, 5'd5, 6'd40, 1'b1, 2'b01);
        lk(5'd5, "R2");
        lk(5'd6, "R3");

        // R4: disabled slot with the same key, lower number
        wr(1, 1'b0, 5'd5, 6'd10, 1'b0, 2'b10);
        lk(5'd5, "R4");

        // R5: two enabled matches, lowest slot wins; R8 byte code
        wr(0, 1'b1, 5'd5, 6'd63, 1'b0, 2'b11);
        wr(7, 1'b1, 5'd5, 6'd20, 1'b1, 2'b10);
        lk(5'd5, "R5");

        // R6: write and lookup in one cycle sees the old table, then the new
        step(1'b1, 2, 1'b1, 5'd9, 6'd33, 1'b1, 2'b10, 1'b1, 5'd9, "R6");
        lk(5'd9, "R6");
        lk(5'd9, "R8");

        // R9: disable slot 0, slot 3 takes over; then overwrite slot 3
        wr(0, 1'b0, 5'd5, 6'd63, 1'b0, 2'b11);
        lk(5'd5, "R9");
        wr(3, 1'b1, 5'd12, 6'd1, 1'b0, 2'b00);
        lk(5'd5, "R9");
        lk(5'd12, "R9");

        // R2 R5: top key and top slot
        wr(15, 1'b1, 5'd31, 6'd47, 1'b1, 2'b00);
        lk(5'd31, "R2");

        // R7: idle gap, then a back-to-back sweep of every operand
        idle(); idle(); idle();
        for (int r = 0; r < 32; r++) lk(5'(r), "R2");
        idle(); idle(); idle();

        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R7: pending results got %0d expected 0", sb.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, got no end expected end");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule